// File: doc/BRIEF.md
# Two-Digit Decimal Up/Down Counter with Selectable Step Rate

This block keeps a count from 00 to 99 as two BCD digits and shows each digit as an active-low seven-segment pattern. All of its logic runs on one system clock. An internal tick generator makes a one-cycle enable pulse once per second, or once every two seconds when the rate input is set. Each pulse moves the count one step. The direction comes from two active-low push-button inputs, and the count wraps at both ends.

The number of clock cycles in one second is the parameter `TICKS_PER_SEC`, 50,000,000 by default. A simulation can set it small. The rate and button inputs pass through a two-flop synchronizer before any logic uses them. The rate input may change while the counter runs. When it does, the tick generator starts its interval again from zero, so one interval is never a mix of the old period and the new one.

Top module: `dec_updown_top`

## Requirements
- R1: The count stays within 00..99. An up step from 99 gives 00, and a down step from 00 gives 99.
- R2: On each tick the count goes up by one when only the up button is pressed, and down by one when only the down button is pressed.
- R3: When both buttons are pressed, or when neither is, a tick leaves the count unchanged.
- R4: With the rate input low, steps are `TICKS_PER_SEC` cycles apart. With it high, they are 2×`TICKS_PER_SEC` cycles apart. The first step after reset lands on the (`TICKS_PER_SEC`+1)th rising edge after reset is released.
- R5: Reset is synchronous and active low. While it is low, both digits show 0 and the count does not move, whatever the buttons do.
- R6: The ones digit carries into the tens digit on an up step from 9 (for example 09 to 10), and borrows from it on a down step from 0 (for example 10 to 09).
- R7: Segment outputs are active low, with bit 0 as segment a through bit 6 as segment g. The patterns for digits 0 to 9 are 1000000, 1111001, 0100100, 0110000, 0011001, 0010010, 0000010, 1111000, 0000000, 0010000.
- R8: A change on the rate input restarts the interval three rising edges after the input changes. The next step then lands a full new period later, at edge 2×`TICKS_PER_SEC`+4 for slow and `TICKS_PER_SEC`+4 for fast, counted from the change.
- R9: The button inputs are active low: a 0 means pressed. Button and rate inputs reach the logic through two flip-flops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_slow | input | 1 | 1 selects one step per two seconds |
| btn_up_n | input | 1 | Count-up button, active low |
| btn_dn_n | input | 1 | Count-down button, active low |
| seg_ones | output | 7 | Ones digit segments, active low, bit 0 = a |
| seg_tens | output | 7 | Tens digit segments, active low, bit 0 = a |

## Verification
The assertions assume that the button and rate inputs change no more often than the synchronizer can follow. They also assume that `TICKS_PER_SEC` is at least 2, so that two ticks can never fall on adjacent cycles. The stimulus changes inputs only on falling clock edges and only in the middle of a step interval. This keeps every change far from a tick, so the two synchronizer cycles never overlap a step edge. The one exception is the rate change itself, which the bench times so that the old interval cannot finish before the restart.

// File: rtl/dcnt_pkg.sv
// Shared types and the segment encoder for the decimal up/down counter.
// Assumes a common digit width of four bits (BCD).
package dcnt_pkg;

    typedef logic [3:0] bcd_t;
    typedef logic [6:0] seg_t;

    // Active-low segment pattern, bit 0 = segment a; non-BCD values blank.
    function automatic seg_t seg_of(input bcd_t d);
        seg_t s;
        case (d)
            4'd0:    s = 7'b1000000;
            4'd1:    s = 7'b1111001;
            4'd2:    s = 7'b0100100;
            4'd3:    s = 7'b0110000;
            4'd4:    s = 7'b0011001;
            4'd5:    s = 7'b0010010;
            4'd6:    s = 7'b0000010;
            4'd7:    s = 7'b1111000;
            4'd8:    s = 7'b0000000;
            4'd9:    s = 7'b0010000;
            default: s = 7'b1111111;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/dcnt_sync.sv
// Two-flop synchronizer for a bundle of slow asynchronous inputs.
// Assumes each bit is independent; reset loads RST_VAL (the idle level).
module dcnt_sync #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);

    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    // Shift the inputs through two register stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= d_in;
            stab_q <= meta_q;
        end
    end

    assign d_out = stab_q;

endmodule

// File: rtl/dcnt_tick.sv
// Step-enable generator: one-cycle pulse every TICKS_PER_SEC cycles, or every
// 2*TICKS_PER_SEC when slow is high. A change of slow restarts the interval.
// Assumes slow is already synchronous and TICKS_PER_SEC >= 2.
module dcnt_tick #(
    parameter int unsigned TICKS_PER_SEC = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow,
    output logic tick
);

    localparam int unsigned FAST_LAST = TICKS_PER_SEC - 1;
    localparam int unsigned SLOW_LAST = 2 * TICKS_PER_SEC - 1;
    localparam int unsigned CW        = $clog2(SLOW_LAST + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;
    logic          slow_q;
    logic          rate_chg;

    // Terminal count for the currently selected period.
    always_comb begin
        last = slow ? CW'(SLOW_LAST) : CW'(FAST_LAST);
    end

    assign rate_chg = (slow != slow_q);

    // Remember the rate used by the running interval.
    always_ff @(posedge clk) begin
        if (!rst_n) slow_q <= slow;
        else        slow_q <= slow;
    end

    // Interval counter and registered tick pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (rate_chg) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (cnt_q == last) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            tick  <= 1'b0;
        end
    end

    // R4: the enable is a single-cycle pulse.
    p_tick_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R4: the interval counter never passes the longest period.
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(SLOW_LAST));

    // R8: a rate change starts the interval again without a pulse.
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rate_chg |=> (cnt_q == '0 && !tick));

endmodule

// File: rtl/dcnt_digit.sv
// One BCD digit with up/down stepping, carry on 9->0 and borrow on 0->9.
// Assumes inc and dec are never high together.
module dcnt_digit
    import dcnt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output bcd_t val,
    output logic carry,
    output logic borrow
);

    assign carry  = inc && (val == 4'd9);
    assign borrow = dec && (val == 4'd0);

    // Step the digit, wrapping within 0..9.
    always_ff @(posedge clk) begin
        if (!rst_n)     val <= 4'd0;
        else if (inc)   val <= (val == 4'd9) ? 4'd0 : val + 4'd1;
        else if (dec)   val <= (val == 4'd0) ? 4'd9 : val - 4'd1;
    end

    // R6: digit always holds a decimal value.
    p_digit_bcd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        val <= 4'd9);

    // R6: a carry out leaves the digit at zero.
    p_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        carry |=> val == 4'd0);

    // R6: a borrow out leaves the digit at nine.
    p_borrow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        borrow |=> val == 4'd9);

endmodule

// File: rtl/dcnt_bcd.sv
// Chain of DIGITS BCD digits; carry and borrow ripple from digit 0 upward.
// Assumes step_up and step_dn are one-cycle pulses and mutually exclusive.
module dcnt_bcd
    import dcnt_pkg::*;
#(
    parameter int DIGITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_up,
    input  logic              step_dn,
    output bcd_t [DIGITS-1:0] digits
);

    logic [DIGITS:0] inc_c;
    logic [DIGITS:0] dec_c;

    assign inc_c[0] = step_up;
    assign dec_c[0] = step_dn;

    genvar i;
    generate
        for (i = 0; i < DIGITS; i++) begin : g_dig
            dcnt_digit u_dig (
                .clk    (clk),
                .rst_n  (rst_n),
                .inc    (inc_c[i]),
                .dec    (dec_c[i]),
                .val    (digits[i]),
                .carry  (inc_c[i+1]),
                .borrow (dec_c[i+1])
            );
        end
    endgenerate

    // True when every digit reads nine.
    function automatic logic all_nine(input bcd_t [DIGITS-1:0] d);
        logic r;
        r = 1'b1;
        for (int k = 0; k < DIGITS; k++) r = r && (d[k] == 4'd9);
        return r;
    endfunction

    // R3: without a step request the count is frozen.
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_up || step_dn) |=> $stable(digits));

    // R1: carry out of the top digit wraps the whole count to zero.
    p_wrap_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
        inc_c[DIGITS] |=> digits == '0);

    // R1: borrow out of the top digit wraps the whole count to all nines.
    p_wrap_dn_r1: assert property (@(posedge clk) disable iff (!rst_n)
        dec_c[DIGITS] |=> all_nine(digits));

endmodule

// File: rtl/dec_updown_top.sv
// Two-digit decimal up/down counter with selectable step rate and
// active-low seven-segment outputs. Inputs are asynchronous board signals;
// buttons are active low and assumed already debounced.
module dec_updown_top
    import dcnt_pkg::*;
#(
    parameter int unsigned TICKS_PER_SEC = 50_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rate_slow,
    input  logic       btn_up_n,
    input  logic       btn_dn_n,
    output logic [6:0] seg_ones,
    output logic [6:0] seg_tens
);

    localparam int DIGITS = 2;

    logic [2:0]        raw_in;
    logic [2:0]        syn_in;
    logic              slow_s;
    logic              up_pressed;
    logic              dn_pressed;
    logic              tick;
    logic              step_up;
    logic              step_dn;
    bcd_t [DIGITS-1:0] digits;

    assign raw_in = {rate_slow, btn_up_n, btn_dn_n};

    dcnt_sync #(.W(3), .RST_VAL(3'b011)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (raw_in),
        .d_out (syn_in)
    );

    assign slow_s     = syn_in[2];
    assign up_pressed = !syn_in[1];
    assign dn_pressed = !syn_in[0];

    dcnt_tick #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .slow  (slow_s),
        .tick  (tick)
    );

    // Exactly one button pressed gives a direction; otherwise hold.
    always_comb begin
        step_up = tick && up_pressed && !dn_pressed;
        step_dn = tick && dn_pressed && !up_pressed;
    end

    dcnt_bcd #(.DIGITS(DIGITS)) u_bcd (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_up (step_up),
        .step_dn (step_dn),
        .digits  (digits)
    );

    // Segment encoding for each digit.
    always_comb begin
        seg_ones = seg_of(digits[0]);
        seg_tens = seg_of(digits[1]);
    end

    // R2: never step both ways at once.
    p_one_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_up && step_dn));

    // R5: a reset cycle leaves both displays at zero.
    p_reset_zero_r5: assert property (@(posedge clk)
        !rst_n |=> (seg_ones == 7'b1000000 && seg_tens == 7'b1000000));

endmodule

// File: tb/tb_dec_updown_top.sv
module tb_dec_updown_top;

    localparam int TPS = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rate_slow = 1'b0;
    logic       btn_up_n = 1'b1;
    logic       btn_dn_n = 1'b1;
    logic [6:0] seg_ones;
    logic [6:0] seg_tens;

    int n_chk  = 0;
    int n_fail = 0;
    int model  = 0;

    always #2.5 clk = ~clk;

    dec_updown_top #(.TICKS_PER_SEC(TPS)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rate_slow (rate_slow),
        .btn_up_n  (btn_up_n),
        .btn_dn_n  (btn_dn_n),
        .seg_ones  (seg_ones),
        .seg_tens  (seg_tens)
    );

    // Expected active-low pattern from the R7 table.
    function automatic logic [6:0] pat(input int d);
        case (d)
            0: return 7'b1000000;  1: return 7'b1111001;
            2: return 7'b0100100;  3: return 7'b0110000;
            4: return 7'b0011001;  5: return 7'b0010010;
            6: return 7'b0000010;  7: return 7'b1111000;
            8: return 7'b0000000;  9: return 7'b0010000;
            default: return 7'b1111111;
        endcase
    endfunction

    task automatic check(input string req, input int exp);
        logic [13:0] want;
        want = {pat(exp / 10), pat(exp % 10)};
        n_chk++;
        if ({seg_tens, seg_ones} !== want) begin
            n_fail++;
            $display("FAIL %s: segs %b_%b expected %b_%b (count %0d)",
                     req, seg_tens, seg_ones, want[13:7], want[6:0], exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Step the model by one period's worth, per the current buttons.
    function automatic int next_count(input int c);
        if (!btn_up_n && btn_dn_n) return (c + 1) % 100;
        if (btn_up_n && !btn_dn_n) return (c + 99) % 100;
        return c;
    endfunction

    task automatic run_periods(input string req, input int n, input int per);
        for (int i = 0; i < n; i++) begin
            cycles(per);
            model = next_count(model);
            check(req, model);
        end
    endtask

    // Release reset and land in the middle of the first interval.
    task automatic release_reset();
        rst_n = 1'b1;
        cycles(TPS / 2);
        model = 0;
        check("R4 before first step", 0);
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0; btn_up_n = 1'b0; btn_dn_n = 1'b1; rate_slow = 1'b0;
        cycles(4);
        check("R5 reset state", 0);
        release_reset();
    endtask

    task automatic t_up_carry();
        run_periods("R2 R6 R9 up with carry", 12, TPS);
    endtask

    task automatic t_down_borrow();
        btn_up_n = 1'b1; btn_dn_n = 1'b0;
        run_periods("R2 R6 down with borrow", 5, TPS);
    endtask

    task automatic t_down_wrap();
        run_periods("R1 down wrap", 9, TPS);
    endtask

    task automatic t_up_wrap();
        btn_up_n = 1'b0; btn_dn_n = 1'b1;
        run_periods("R1 up wrap", 3, TPS);
    endtask

    task automatic t_hold_combos();
        btn_up_n = 1'b0; btn_dn_n = 1'b0;
        run_periods("R3 both pressed", 3, TPS);
        btn_up_n = 1'b1; btn_dn_n = 1'b1;
        run_periods("R3 none pressed", 3, TPS);
        btn_up_n = 1'b0;
    endtask

    task automatic t_rate_change();
        rate_slow = 1'b1;
        cycles(2 * TPS + 2);
        check("R8 no step before slow period", model);
        cycles(4);
        model = next_count(model);
        check("R8 step after slow period", model);
        cycles(TPS - 2);
        run_periods("R4 slow rate", 2, 2 * TPS);
        rate_slow = 1'b0;
        cycles(TPS + 2);
        check("R8 no step before fast period", model);
        cycles(4);
        model = next_count(model);
        check("R8 step after fast period", model);
        cycles(TPS / 2 - 2);
        run_periods("R4 fast rate", 2, TPS);
    endtask

    task automatic t_reset_hold();
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            cycles(TPS);
            check("R5 held in reset", 0);
        end
        release_reset();
        run_periods("R4 R5 count resumes", 2, TPS);
    endtask

    initial begin
        t_reset_state();
        t_up_carry();
        t_down_borrow();
        t_down_wrap();
        t_up_wrap();
        t_hold_combos();
        t_rate_change();
        t_reset_hold();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not end, actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule